// File: doc/BRIEF.md
# Throttle Event Arbiter

The arbiter collects several throttle requests that may be raised at the same time and decides which single set of throttle settings reaches the clock skippers. Two of the sources are temperature events, a light one at index 0 and a heavy one at index 1. Each is raised while a shared temperature reading is strictly above that event's own hot threshold. The remaining source, index 2, is an overcurrent alarm that arrives as a plain request input.

Every source owns a settings word with three fields: a numeric priority, a CPU skip depth in percent and a GPU throttle level code. When one or more enabled sources request, the block forwards the whole settings bundle of the highest-priority requester and raises a throttle-active flag. Software programs the settings and thresholds through a plain write strobe with an address and a data word. The applied settings are registered, so downstream clock logic sees a clean value once per cycle.

Top module: `throttle_arbiter`

## Requirements
- R1: After reset every event has priority 0, depth 0, level 0 and a threshold of all ones. The outputs read depth 0, level 0 and throttle-active low, even with the temperature at its maximum and the overcurrent request high.
- R2: A temperature event (index 0 light, index 1 heavy) requests only while `temp_i` is strictly greater than its threshold. A reading equal to the threshold raises no request.
- R3: The overcurrent event (index 2) requests while its bit of `oc_req_i` is 1.
- R4: An event whose priority is 0 is disabled and never wins, even while it requests.
- R5: Among requesting enabled events, the one with the numerically largest priority wins. `cpu_pct_o` and `gpu_lvl_o` then carry that event's depth and level, and `throt_active_o` is 1.
- R6: When requesting enabled events share the largest priority, the one with the lowest index wins.
- R7: With no requesting enabled event, the outputs are depth 0, level 0 and throttle-active low.
- R8: The outputs are registered. They change at the first rising edge after the request set or the stored settings change, and not before it.
- R9: A write occurs on a rising edge with `wr_en` high. `wr_addr[0]` selects the settings word (0) or the threshold (1), and `wr_addr[2:1]` selects the event index. In the settings word, bits [6:0] are the priority, [14:8] the CPU depth and [17:16] the GPU level. The threshold takes bits [11:0]. Writes to event index 3, and threshold writes to the overcurrent event, change nothing.
- R10: A written priority or CPU depth above 100 is stored as 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | {event index, word select} |
| wr_data | input | 32 | Write data |
| temp_i | input | 12 | Temperature reading, unsigned |
| oc_req_i | input | 1 | Overcurrent request |
| cpu_pct_o | output | 7 | Applied CPU skip depth, percent |
| gpu_lvl_o | output | 2 | Applied GPU throttle level code |
| throt_active_o | output | 1 | Some enabled event is throttling |

## Verification
A settings write and a change in the request set can land on the same rising edge. The random phase provokes this on purpose by driving a write together with a new temperature and overcurrent value in the same cycle. The first result after that edge is judged against the old settings combined with the new requests. The next result is judged against the new settings. Directed cases add exact threshold equality, priority ties, saturated values and writes to the empty index, and each is compared with a bench model of the arbitration.

// File: rtl/thr_arb_pkg.sv
package thr_arb_pkg;
   localparam int unsigned PRIO_W   = 7;
   localparam int unsigned PCT_W    = 7;
   localparam int unsigned LVL_W    = 2;
   localparam int unsigned PRIO_MAX = 100;
   localparam int unsigned PCT_MAX  = 100;

   // field positions of the settings word
   localparam int unsigned PRIO_LSB = 0;
   localparam int unsigned PCT_LSB  = 8;
   localparam int unsigned LVL_LSB  = 16;

   typedef struct packed {
      logic [PRIO_W-1:0] prio;
      logic [PCT_W-1:0]  pct;
      logic [LVL_W-1:0]  lvl;
   } evt_cfg_t;

   function automatic logic [PRIO_W-1:0] clamp_prio(input logic [PRIO_W-1:0] v);
      return (v > PRIO_W'(PRIO_MAX)) ? PRIO_W'(PRIO_MAX) : v;
   endfunction

   function automatic logic [PCT_W-1:0] clamp_pct(input logic [PCT_W-1:0] v);
      return (v > PCT_W'(PCT_MAX)) ? PCT_W'(PCT_MAX) : v;
   endfunction
endpackage

// File: rtl/thr_cfg_regs.sv
module thr_cfg_regs
   import thr_arb_pkg::*;
#(
   parameter int NUM_EVT  = 3,
   parameter int NUM_TEMP = 2,
   parameter int TEMP_W   = 12,
   parameter int DATA_W   = 32,
   parameter int EVT_W    = 2,
   parameter int ADDR_W   = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output evt_cfg_t          cfg_o [NUM_EVT],
   output logic [TEMP_W-1:0] thr_o [NUM_TEMP]
);
   logic unused_wdata;
   assign unused_wdata = ^wr_data;

   evt_cfg_t wr_cfg;
   always_comb begin
      wr_cfg.prio = clamp_prio(wr_data[PRIO_LSB +: PRIO_W]);
      wr_cfg.pct  = clamp_pct(wr_data[PCT_LSB +: PCT_W]);
      wr_cfg.lvl  = wr_data[LVL_LSB +: LVL_W];
   end

   for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
      logic hit;
      assign hit = wr_en && (wr_addr[ADDR_W-1:1] == EVT_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 cfg_o[i] <= '0;
         else if (hit && !wr_addr[0]) cfg_o[i] <= wr_cfg;
      end

      if (i < NUM_TEMP) begin : g_thr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                thr_o[i] <= '1;
            else if (hit && wr_addr[0]) thr_o[i] <= wr_data[TEMP_W-1:0];
         end
      end

      // R10: stored fields never exceed their ceiling
      p_cfg_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_o[i].prio <= PRIO_W'(PRIO_MAX)) && (cfg_o[i].pct <= PCT_W'(PCT_MAX)));
   end
endmodule

// File: rtl/thr_evt_detect.sv
module thr_evt_detect #(
   parameter int NUM_EVT  = 3,
   parameter int NUM_TEMP = 2,
   parameter int TEMP_W   = 12,
   parameter int NUM_OC   = 1
)(
   input  logic [TEMP_W-1:0] temp_i,
   input  logic [TEMP_W-1:0] thr_i [NUM_TEMP],
   input  logic [NUM_OC-1:0] oc_req_i,
   output logic [NUM_EVT-1:0] req_o
);
   for (genvar i = 0; i < NUM_EVT; i++) begin : g_req
      if (i < NUM_TEMP) begin : g_temp
         assign req_o[i] = temp_i > thr_i[i];
      end else begin : g_oc
         assign req_o[i] = oc_req_i[i-NUM_TEMP];
      end
   end
endmodule

// File: rtl/thr_prio_pick.sv
module thr_prio_pick
   import thr_arb_pkg::*;
#(
   parameter int NUM_EVT = 3
)(
   input  logic [NUM_EVT-1:0] req_i,
   input  evt_cfg_t           cfg_i [NUM_EVT],
   output logic               win_valid_o,
   output evt_cfg_t           win_cfg_o
);
   // strict compare keeps the lowest index on equal priority;
   // a priority of zero can never exceed the running best
   always_comb begin
      win_cfg_o   = '0;
      win_valid_o = 1'b0;
      for (int i = 0; i < NUM_EVT; i++) begin
         if (req_i[i] && (cfg_i[i].prio > win_cfg_o.prio)) begin
            win_cfg_o   = cfg_i[i];
            win_valid_o = 1'b1;
         end
      end
   end
endmodule

// File: rtl/throttle_arbiter.sv
module throttle_arbiter
   import thr_arb_pkg::*;
#(
   parameter  int NUM_EVT  = 3,
   parameter  int NUM_TEMP = 2,
   parameter  int TEMP_W   = 12,
   parameter  int DATA_W   = 32,
   localparam int EVT_W    = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1,
   localparam int ADDR_W   = EVT_W + 1,
   localparam int NUM_OC   = NUM_EVT - NUM_TEMP
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [TEMP_W-1:0] temp_i,
   input  logic [NUM_OC-1:0] oc_req_i,
   output logic [PCT_W-1:0]  cpu_pct_o,
   output logic [LVL_W-1:0]  gpu_lvl_o,
   output logic              throt_active_o
);
   if (NUM_TEMP < 1 || NUM_TEMP >= NUM_EVT) begin : g_bad_split
      $error("need at least one temperature event and one overcurrent event");
   end
   if (TEMP_W > DATA_W || DATA_W < LVL_LSB + LVL_W) begin : g_bad_width
      $error("data word too narrow for the fields it carries");
   end

   evt_cfg_t           cfg [NUM_EVT];
   logic [TEMP_W-1:0]  thr [NUM_TEMP];
   logic [NUM_EVT-1:0] req;
   logic               win_valid;
   evt_cfg_t           win_cfg;

   thr_cfg_regs #(
      .NUM_EVT(NUM_EVT), .NUM_TEMP(NUM_TEMP), .TEMP_W(TEMP_W),
      .DATA_W(DATA_W), .EVT_W(EVT_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .cfg_o(cfg), .thr_o(thr)
   );

   thr_evt_detect #(
      .NUM_EVT(NUM_EVT), .NUM_TEMP(NUM_TEMP), .TEMP_W(TEMP_W), .NUM_OC(NUM_OC)
   ) u_detect (
      .temp_i(temp_i), .thr_i(thr), .oc_req_i(oc_req_i), .req_o(req)
   );

   thr_prio_pick #(.NUM_EVT(NUM_EVT)) u_pick (
      .req_i(req), .cfg_i(cfg), .win_valid_o(win_valid), .win_cfg_o(win_cfg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_pct_o      <= '0;
         gpu_lvl_o      <= '0;
         throt_active_o <= 1'b0;
      end else if (win_valid) begin
         cpu_pct_o      <= win_cfg.pct;
         gpu_lvl_o      <= win_cfg.lvl;
         throt_active_o <= 1'b1;
      end else begin
         cpu_pct_o      <= '0;
         gpu_lvl_o      <= '0;
         throt_active_o <= 1'b0;
      end
   end

   // R7: idle output carries neutral settings
   p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !throt_active_o |-> (cpu_pct_o == '0) && (gpu_lvl_o == '0));

   // R4: throttling only follows a cycle in which some event requested
   p_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (throt_active_o && $past(rst_n)) |-> $past(|req));

   // R8: unchanged inputs and settings keep the outputs unchanged
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(wr_en) && $stable(temp_i) && $stable(oc_req_i))
      |=> $stable({cpu_pct_o, gpu_lvl_o, throt_active_o}));

   // R10: applied depth stays within range
   p_pct_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_pct_o <= PCT_W'(PCT_MAX));
endmodule

// File: tb/throttle_arbiter_tb.sv
`timescale 1ns/1ps
module throttle_arbiter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [11:0] temp_i = '0;
   logic [0:0]  oc_req_i = '0;
   logic [6:0]  cpu_pct_o;
   logic [1:0]  gpu_lvl_o;
   logic        throt_active_o;

   int n_chk = 0;
   int n_fail = 0;

   // bench model
   int m_prio [3];
   int m_pct  [3];
   int m_lvl  [3];
   int m_thr  [2];

   always #4 clk = ~clk;

   throttle_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .temp_i(temp_i), .oc_req_i(oc_req_i),
      .cpu_pct_o(cpu_pct_o), .gpu_lvl_o(gpu_lvl_o), .throt_active_o(throt_active_o)
   );

   function automatic int sat(input int v);
      return (v > 100) ? 100 : v;
   endfunction

   function automatic void mdl_reset();
      for (int i = 0; i < 3; i++) begin
         m_prio[i] = 0; m_pct[i] = 0; m_lvl[i] = 0;
      end
      for (int i = 0; i < 2; i++) m_thr[i] = 4095;
   endfunction

   function automatic void mdl_wr(input int idx, input int sel, input logic [31:0] d);
      if (idx >= 3) return;
      if (sel == 0) begin
         m_prio[idx] = sat(int'(d[6:0]));
         m_pct[idx]  = sat(int'(d[14:8]));
         m_lvl[idx]  = int'(d[17:16]);
      end else if (idx < 2) begin
         m_thr[idx] = int'(d[11:0]);
      end
   endfunction

   function automatic void calc(input int t, input int oc,
                                output int ep, output int el, output int ea);
      int best;
      best = 0; ep = 0; el = 0; ea = 0;
      for (int i = 0; i < 3; i++) begin
         bit r;
         r = (i < 2) ? (t > m_thr[i]) : (oc != 0);
         if (r && m_prio[i] > best) begin
            best = m_prio[i]; ep = m_pct[i]; el = m_lvl[i]; ea = 1;
         end
      end
   endfunction

   function automatic logic [31:0] cfg_word(input int prio, input int pct, input int lvl);
      logic [31:0] w;
      w = '0;
      w[6:0] = 7'(prio); w[14:8] = 7'(pct); w[17:16] = 2'(lvl);
      return w;
   endfunction

   task automatic chk_vals(input string tag, input int ep, input int el, input int ea);
      n_chk++;
      if (int'(cpu_pct_o) != ep || int'(gpu_lvl_o) != el || int'(throt_active_o) != ea) begin
         n_fail++;
         $display("FAIL %s: got pct=%0d lvl=%0d act=%0d, expected pct=%0d lvl=%0d act=%0d",
                  tag, cpu_pct_o, gpu_lvl_o, throt_active_o, ep, el, ea);
      end
   endtask

   task automatic chk(input string tag);
      int ep, el, ea;
      calc(int'(temp_i), int'(oc_req_i), ep, el, ea);
      chk_vals(tag, ep, el, ea);
   endtask

   // called at a negedge; returns at a negedge
   task automatic wr(input int idx, input int sel, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = {2'(idx), 1'(sel)}; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      mdl_wr(idx, sel, d);
   endtask

   task automatic apply(input int t, input int oc, input string tag);
      temp_i = 12'(t); oc_req_i = 1'(oc);
      @(negedge clk);
      chk(tag);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      int ep0, el0, ea0;
      void'($urandom(32'h5eed_0042));
      mdl_reset();
      repeat (3) @(negedge clk);
      chk("R1");
      rst_n = 1'b1;
      @(negedge clk);
      apply(4095, 1, "R1");                     // max temp, oc high, all disabled

      // program: light 80/50/1 thr 1000, heavy 100/85/3 thr 1200, oc 50/75/2
      wr(0, 0, cfg_word(80, 50, 1));
      wr(0, 1, 32'd1000);
      wr(1, 0, cfg_word(100, 85, 3));
      wr(1, 1, 32'd1200);
      wr(2, 0, cfg_word(50, 75, 2));
      apply(1000, 0, "R2");                      // equal: no request
      apply(1001, 0, "R2");                      // light only
      apply(1201, 0, "R5");                      // heavy over light
      apply(500, 1, "R3");                       // oc alone
      apply(1101, 1, "R5");                      // light 80 over oc 50

      // R8: no change before the edge, change after it
      calc(int'(temp_i), int'(oc_req_i), ep0, el0, ea0);
      temp_i = 12'd1300;
      #2;
      chk_vals("R8", ep0, el0, ea0);
      @(negedge clk);
      chk("R8");

      // R4: disable heavy while it requests
      wr(1, 0, cfg_word(0, 85, 3));
      apply(1300, 0, "R4");
      // R6: oc tied with light at 80, light (index 0) wins
      wr(2, 0, cfg_word(80, 75, 2));
      apply(1300, 1, "R6");
      // R10: heavy written 127/120 saturates to 100/100
      wr(1, 0, cfg_word(127, 120, 3));
      apply(1300, 1, "R10");
      wr(0, 0, cfg_word(100, 50, 1));            // tie at 100 proves heavy is not 127
      apply(1300, 1, "R10");
      // R9: writes to index 3 and oc threshold change nothing
      wr(3, 0, cfg_word(127, 9, 0));
      wr(3, 1, 32'd0);
      wr(2, 1, 32'd0);
      apply(1300, 1, "R9");
      apply(1001, 0, "R9");
      // R7: nothing requesting
      apply(10, 0, "R7");

      // random phase; writes may coincide with request changes
      wr(0, 1, 32'd20);
      wr(1, 1, 32'd40);
      for (int k = 0; k < 400; k++) begin
         int idx, sel;
         logic [31:0] d;
         bit do_wr;
         do_wr = ($urandom_range(0, 1) == 1);
         idx = $urandom_range(0, 3);
         sel = $urandom_range(0, 1);
         d = $urandom();
         if (sel == 1) d[11:0] = 12'($urandom_range(0, 63));
         if (do_wr) begin
            wr_en = 1'b1; wr_addr = {2'(idx), 1'(sel)}; wr_data = d;
         end
         temp_i = 12'($urandom_range(0, 70));
         oc_req_i = 1'($urandom_range(0, 1));
         @(negedge clk);
         chk("R5");                               // old settings, new requests
         wr_en = 1'b0;
         if (do_wr) mdl_wr(idx, sel, d);
         @(negedge clk);
         chk("R9");                               // new settings applied
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule